// File: doc/BRIEF.md
# Banked Processor Status Register Unit

This block keeps the live status word of a processor core. The word holds four condition flags, two interrupt-disable bits, a compact-instruction-state bit and a five-bit mode field. Next to it the block keeps one saved-status copy for each of the three exception-handling modes (fast interrupt, interrupt, supervisor). When an exception is taken, the block moves the core into the matching mode and stores the previous status word in that mode's saved copy. An exception return puts the saved copy back.

The rest of the core reaches the status word in three ways. An ALU flag update writes the four flags. A software write uses a four-bit byte mask and can target either the live word or the current mode's saved copy. A software read looks at the live word and at the current mode's saved copy on two outputs. Privilege rules apply to every access: user mode is the only unprivileged mode, and user mode and system mode have no saved copy. When several requests arrive in the same cycle, one fixed priority picks the single request that takes effect.

Top module: `psr_bank_unit`

## Requirements
- R1: A synchronous reset sets the live word to 0x000000D3: supervisor mode 10011, IRQ-disable set, FIQ-disable set, all flags clear. The same reset sets each saved copy to 0x00000010 (user mode).
- R2: The live word has a fixed layout. N is bit 31, Z is bit 30, C is bit 29 and V is bit 28. IRQ-disable is bit 7, FIQ-disable is bit 6 and the compact-state bit is bit 5. The mode field is bits [4:0]. Every other bit always reads zero.
- R3: A fast-interrupt request stores the prior live word in the fast-interrupt saved copy. It sets mode 10001, sets both disable bits, clears the compact-state bit and keeps the flags.
- R4: An interrupt request stores the prior word in the interrupt saved copy. It sets mode 10010, sets IRQ-disable, clears the compact-state bit and keeps FIQ-disable and the flags.
- R5: A supervisor-call request stores the prior word in the supervisor saved copy and sets mode 10011. The bits follow the same rule as R4.
- R6: `saved_o` shows the saved copy of the current mode. It reads zero in user mode (10000) and in system mode (11111). A saved-copy write in those two modes has no effect.
- R7: In a mode that has a saved copy, an exception return loads that saved copy into the live word at the next edge. A return in user or system mode changes nothing.
- R8: A software write changes only the bytes that its mask selects: mask bit 3 selects [31:24], bit 2 selects [23:16], bit 1 selects [15:8] and bit 0 selects [7:0]. `wr_saved_i`=1 targets the current saved copy; otherwise the write targets the live word. A mask of 1111 writes the whole word.
- R9: In user mode a software write never changes live bits [7:0]. The flags byte still takes its selected value.
- R10: When a written control byte carries a mode value that is none of the five legal encodings, the whole control byte is ignored. The other selected bytes are still written.
- R11: An ALU update copies `alu_flags_i[3:0]` into N, Z, C and V (bits 31..28) at the next edge and leaves the other bits unchanged.
- R12: Only one request takes effect per cycle, chosen in this order: reset, fast interrupt, interrupt, supervisor call, return, software write, ALU update. The requests with lower priority in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fiq_req_i | input | 1 | Take fast-interrupt exception |
| irq_req_i | input | 1 | Take interrupt exception |
| svc_req_i | input | 1 | Take supervisor-call exception |
| ret_req_i | input | 1 | Exception return strobe |
| wr_en_i | input | 1 | Software write strobe |
| wr_saved_i | input | 1 | Write targets the saved copy (1) or the live word (0) |
| wr_mask_i | input | 4 | Byte mask of the write |
| wr_data_i | input | 32 | Write data |
| alu_en_i | input | 1 | ALU flag update strobe |
| alu_flags_i | input | 4 | New N, Z, C, V (bit 3 down to 0) |
| status_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved copy of the current mode, zero in user/system |

## Verification
Every request takes effect at the first rising edge that samples it. Directly after that edge, `status_o` shows the new word, and `saved_o` shows the copy that the new mode selects. An exception entry therefore shows the stored prior word at once. The bench drives inputs one time unit after a rising edge, waits for the next rising edge, and samples both outputs one time unit later. Each check therefore covers exactly one edge of the design against a bench model that has advanced by exactly one step.

// File: rtl/psr_bank_pkg.sv
package psr_bank_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned NUM_BANKS = 3;
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS);
  localparam int unsigned NUM_BYTES = WORD_W / 8;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [BANK_W-1:0] bank_t;

  localparam mode_t M_USR = 5'b10000;
  localparam mode_t M_FIQ = 5'b10001;
  localparam mode_t M_IRQ = 5'b10010;
  localparam mode_t M_SVC = 5'b10011;
  localparam mode_t M_SYS = 5'b11111;

  localparam bank_t B_FIQ = 2'd0;
  localparam bank_t B_IRQ = 2'd1;
  localparam bank_t B_SVC = 2'd2;

  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_T = 5;
  localparam int unsigned FLAG_LO = 28;

  localparam logic [WORD_W-1:0] LIVE_MASK  = 32'hF000_00FF;
  localparam logic [WORD_W-1:0] RESET_LIVE = 32'h0000_00D3;
  localparam logic [WORD_W-1:0] RESET_SAVE = 32'h0000_0010;

  function automatic logic mode_ok(input mode_t m);
    return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) ||
           (m == M_SVC) || (m == M_SYS);
  endfunction

  function automatic logic [WORD_W-1:0] masked_merge(
      input logic [WORD_W-1:0]    old_w,
      input logic [WORD_W-1:0]    new_w,
      input logic [NUM_BYTES-1:0] mask,
      input logic                 allow_ctrl);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (mask[b] && (b != 0 || allow_ctrl)) r[8*b +: 8] = new_w[8*b +: 8];
    end
    if (!mode_ok(r[MODE_W-1:0])) r[7:0] = old_w[7:0];
    return r & LIVE_MASK;
  endfunction

endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_bank_pkg::*;
(
  input  mode_t mode_i,
  output logic  priv_o,
  output logic  has_saved_o,
  output bank_t bank_o
);
  always_comb begin
    priv_o      = (mode_i != M_USR);
    has_saved_o = 1'b1;
    bank_o      = B_FIQ;
    unique case (mode_i)
      M_FIQ:   bank_o = B_FIQ;
      M_IRQ:   bank_o = B_IRQ;
      M_SVC:   bank_o = B_SVC;
      default: has_saved_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_bank_pkg::*;
#(
  parameter int unsigned            BANKS  = NUM_BANKS,
  parameter int unsigned            DW     = WORD_W,
  parameter logic [WORD_W-1:0]      INIT_W = RESET_SAVE
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [$clog2(BANKS)-1:0]   widx_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [$clog2(BANKS)-1:0]   ridx_i,
  output logic [DW-1:0]              rdata_o
);
  localparam int unsigned IW = $clog2(BANKS);

  logic [DW-1:0] copy_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)                                copy_q[g] <= INIT_W[DW-1:0];
      else if (we_i && widx_i == IW'(g))      copy_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (ridx_i == IW'(k)) rdata_o = copy_q[k];
    end
  end
endmodule

// File: rtl/psr_next_state.sv
module psr_next_state
  import psr_bank_pkg::*;
(
  input  logic [WORD_W-1:0]    cur_i,
  input  logic [WORD_W-1:0]    saved_i,
  input  logic                 priv_i,
  input  logic                 has_saved_i,
  input  bank_t                bank_i,
  input  logic                 fiq_i,
  input  logic                 irq_i,
  input  logic                 svc_i,
  input  logic                 ret_i,
  input  logic                 wr_en_i,
  input  logic                 wr_saved_i,
  input  logic [NUM_BYTES-1:0] wr_mask_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic                 alu_en_i,
  input  logic [3:0]           alu_flags_i,
  output logic [WORD_W-1:0]    nxt_o,
  output logic                 bank_we_o,
  output bank_t                bank_idx_o,
  output logic [WORD_W-1:0]    bank_d_o
);
  function automatic logic [WORD_W-1:0] enter(
      input logic [WORD_W-1:0] w, input mode_t m, input logic set_f);
    logic [WORD_W-1:0] r;
    r = w;
    r[BIT_I] = 1'b1;
    if (set_f) r[BIT_F] = 1'b1;
    r[BIT_T] = 1'b0;
    r[MODE_W-1:0] = m;
    return r;
  endfunction

  always_comb begin
    nxt_o      = cur_i;
    bank_we_o  = 1'b0;
    bank_idx_o = bank_i;
    bank_d_o   = cur_i;
    if (fiq_i) begin
      bank_we_o  = 1'b1;
      bank_idx_o = B_FIQ;
      nxt_o      = enter(cur_i, M_FIQ, 1'b1);
    end else if (irq_i) begin
      bank_we_o  = 1'b1;
      bank_idx_o = B_IRQ;
      nxt_o      = enter(cur_i, M_IRQ, 1'b0);
    end else if (svc_i) begin
      bank_we_o  = 1'b1;
      bank_idx_o = B_SVC;
      nxt_o      = enter(cur_i, M_SVC, 1'b0);
    end else if (ret_i) begin
      if (has_saved_i) nxt_o = saved_i;
    end else if (wr_en_i) begin
      if (wr_saved_i) begin
        bank_we_o = has_saved_i;
        bank_d_o  = masked_merge(saved_i, wr_data_i, wr_mask_i, priv_i);
      end else begin
        nxt_o = masked_merge(cur_i, wr_data_i, wr_mask_i, priv_i);
      end
    end else if (alu_en_i) begin
      nxt_o[FLAG_LO +: 4] = alu_flags_i;
    end
  end
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
  import psr_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fiq_req_i,
  input  logic        irq_req_i,
  input  logic        svc_req_i,
  input  logic        ret_req_i,
  input  logic        wr_en_i,
  input  logic        wr_saved_i,
  input  logic [3:0]  wr_mask_i,
  input  logic [31:0] wr_data_i,
  input  logic        alu_en_i,
  input  logic [3:0]  alu_flags_i,
  output logic [31:0] status_o,
  output logic [31:0] saved_o
);
  logic [WORD_W-1:0] live_q, live_nxt, bank_rd, bank_d;
  logic              priv, has_saved, bank_we;
  bank_t             cur_bank, bank_idx;

  psr_mode_decode i_decode (
    .mode_i      (live_q[MODE_W-1:0]),
    .priv_o      (priv),
    .has_saved_o (has_saved),
    .bank_o      (cur_bank)
  );

  psr_saved_bank #(
    .BANKS (NUM_BANKS),
    .DW    (WORD_W),
    .INIT_W(RESET_SAVE)
  ) i_bank (
    .clk     (clk),
    .rst     (rst),
    .we_i    (bank_we),
    .widx_i  (bank_idx),
    .wdata_i (bank_d),
    .ridx_i  (cur_bank),
    .rdata_o (bank_rd)
  );

  psr_next_state i_next (
    .cur_i       (live_q),
    .saved_i     (bank_rd),
    .priv_i      (priv),
    .has_saved_i (has_saved),
    .bank_i      (cur_bank),
    .fiq_i       (fiq_req_i),
    .irq_i       (irq_req_i),
    .svc_i       (svc_req_i),
    .ret_i       (ret_req_i),
    .wr_en_i     (wr_en_i),
    .wr_saved_i  (wr_saved_i),
    .wr_mask_i   (wr_mask_i),
    .wr_data_i   (wr_data_i),
    .alu_en_i    (alu_en_i),
    .alu_flags_i (alu_flags_i),
    .nxt_o       (live_nxt),
    .bank_we_o   (bank_we),
    .bank_idx_o  (bank_idx),
    .bank_d_o    (bank_d)
  );

  always_ff @(posedge clk) begin
    if (rst) live_q <= RESET_LIVE;
    else     live_q <= live_nxt;
  end

  assign status_o = live_q;
  assign saved_o  = has_saved ? bank_rd : '0;
endmodule

// File: rtl/psr_bank_checker.sv
module psr_bank_checker
  import psr_bank_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        fiq_req_i,
  input logic        irq_req_i,
  input logic        svc_req_i,
  input logic        ret_req_i,
  input logic        wr_en_i,
  input logic        alu_en_i,
  input logic [3:0]  alu_flags_i,
  input logic [31:0] status_o,
  input logic [31:0] saved_o
);
  logic exc_any;
  assign exc_any = fiq_req_i | irq_req_i | svc_req_i;

  p_reset_word_r1: assert property (@(posedge clk)
    rst |=> status_o == RESET_LIVE);

  p_clean_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (status_o & ~LIVE_MASK) == '0);

  p_fiq_entry_r3: assert property (@(posedge clk) disable iff (rst)
    fiq_req_i |=> status_o[4:0] == M_FIQ && status_o[BIT_I] && status_o[BIT_F]
                  && !status_o[BIT_T]);

  p_fiq_saved_r3: assert property (@(posedge clk) disable iff (rst)
    fiq_req_i |=> saved_o == $past(status_o));

  p_irq_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && !fiq_req_i) |=> status_o[4:0] == M_IRQ && status_o[BIT_I]
      && !status_o[BIT_T] && status_o[BIT_F] == $past(status_o[BIT_F]));

  p_svc_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (svc_req_i && !fiq_req_i && !irq_req_i) |=> status_o[4:0] == M_SVC
      && saved_o == $past(status_o));

  p_no_saved_r6: assert property (@(posedge clk) disable iff (rst)
    (status_o[4:0] == M_USR || status_o[4:0] == M_SYS) |-> saved_o == '0);

  p_ret_unbanked_r7: assert property (@(posedge clk) disable iff (rst)
    (ret_req_i && !exc_any && (status_o[4:0] == M_USR || status_o[4:0] == M_SYS))
      |=> $stable(status_o));

  p_user_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
    (status_o[4:0] == M_USR && !exc_any) |=> $stable(status_o[7:0]));

  p_alu_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (alu_en_i && !exc_any && !ret_req_i && !wr_en_i)
      |=> status_o[31:28] == $past(alu_flags_i));
endmodule

bind psr_bank_unit psr_bank_checker i_psr_bank_checker (
  .clk         (clk),
  .rst         (rst),
  .fiq_req_i   (fiq_req_i),
  .irq_req_i   (irq_req_i),
  .svc_req_i   (svc_req_i),
  .ret_req_i   (ret_req_i),
  .wr_en_i     (wr_en_i),
  .alu_en_i    (alu_en_i),
  .alu_flags_i (alu_flags_i),
  .status_o    (status_o),
  .saved_o     (saved_o)
);

// File: tb/test_psr_bank_unit.sv
`timescale 1ns/1ps
module test_psr_bank_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fiq = 0, irq = 0, svc = 0, ret = 0, wen = 0, wsav = 0, aen = 0;
  logic [3:0]  wmask = 0, aflags = 0;
  logic [31:0] wdata = 0;
  logic [31:0] status, saved;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_live;
  logic [31:0] m_copy [3];

  always #2 clk = ~clk;

  psr_bank_unit i_psr_bank_unit (
    .clk(clk), .rst(rst), .fiq_req_i(fiq), .irq_req_i(irq), .svc_req_i(svc),
    .ret_req_i(ret), .wr_en_i(wen), .wr_saved_i(wsav), .wr_mask_i(wmask),
    .wr_data_i(wdata), .alu_en_i(aen), .alu_flags_i(aflags),
    .status_o(status), .saved_o(saved));

  function automatic bit legal(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h1F};
  endfunction

  function automatic int slot(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] apply_wr(input logic [31:0] o, input logic [31:0] d,
                                           input logic [3:0] mk, input bit user);
    logic [31:0] r = o;
    if (mk[3]) r[31:24] = d[31:24];
    if (mk[2]) r[23:16] = d[23:16];
    if (mk[1]) r[15:8]  = d[15:8];
    if (mk[0] && !user && legal(d[4:0])) r[7:0] = d[7:0];
    return r & 32'hF000_00FF;
  endfunction

  function automatic logic [31:0] m_saved_view();
    int s = slot(m_live[4:0]);
    return (s < 0) ? 32'h0 : m_copy[s];
  endfunction

  task automatic model_step();
    int s = slot(m_live[4:0]);
    if (rst) begin
      m_live = 32'hD3;
      for (int k = 0; k < 3; k++) m_copy[k] = 32'h10;
    end else if (fiq) begin
      m_copy[0] = m_live; m_live = {m_live[31:8], 3'b110, 5'h11};
    end else if (irq) begin
      m_copy[1] = m_live; m_live = {m_live[31:8], 1'b1, m_live[6], 1'b0, 5'h12};
    end else if (svc) begin
      m_copy[2] = m_live; m_live = {m_live[31:8], 1'b1, m_live[6], 1'b0, 5'h13};
    end else if (ret) begin
      if (s >= 0) m_live = m_copy[s];
    end else if (wen) begin
      if (wsav) begin
        if (s >= 0) m_copy[s] = apply_wr(m_copy[s], wdata, wmask, 1'b0);
      end else m_live = apply_wr(m_live, wdata, wmask, m_live[4:0] == 5'h10);
    end else if (aen) m_live[31:28] = aflags;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; fiq = 0; irq = 0; svc = 0; ret = 0; wen = 0; wsav = 0; aen = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic do_wr(input bit sv, input logic [3:0] mk, input logic [31:0] d);
    idle(); wen = 1; wsav = sv; wmask = mk; wdata = d; tick(); idle();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(); tick(); idle();
    check("R1 reset live", status, 32'h0000_00D3);
    check("R1 reset saved", saved, 32'h0000_0010);

    fiq = 1; tick(); idle();
    check("R3 fiq live", status, 32'h0000_00D1);
    check("R3 fiq saved", saved, 32'h0000_00D3);

    do_wr(0, 4'b1001, 32'hA000_0010);
    check("R8 masked write", status, 32'hA000_0010);
    check("R6 user saved zero", saved, 32'h0);

    do_wr(0, 4'hF, 32'h5000_00DF);
    check("R9 user ctrl locked", status, 32'h5000_0010);

    ret = 1; tick(); idle();
    check("R7 user return ignored", status, 32'h5000_0010);

    do_wr(1, 4'hF, 32'hFFFF_FFFF);
    check("R6 user saved write", saved, 32'h0);

    aen = 1; aflags = 4'b0011; tick(); idle();
    check("R11 alu flags", status, 32'h3000_0010);

    irq = 1; tick(); idle();
    check("R4 irq live", status, 32'h3000_0092);
    check("R4 irq saved", saved, 32'h3000_0010);

    do_wr(0, 4'b0001, 32'h0000_00D5);
    check("R10 bad mode ignored", status, 32'h3000_0092);

    svc = 1; ret = 1; wen = 1; wsav = 0; wmask = 4'hF; wdata = 32'h0; aen = 1; aflags = 4'hC;
    tick(); idle();
    check("R12 priority live", status, 32'h3000_0093);
    check("R5 svc saved", saved, 32'h3000_0092);

    ret = 1; tick(); idle();
    check("R7 return restores", status, 32'h3000_0092);

    do_wr(0, 4'hF, 32'hFFFF_FFFF);
    check("R2 unused bits zero", status, 32'hF000_00FF);
    check("R6 system saved zero", saved, 32'h0);

    ret = 1; tick(); idle();
    check("R7 system return ignored", status, 32'hF000_00FF);

    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      rst  = ($urandom % 100) < 1;
      fiq  = ($urandom % 100) < 3;
      irq  = ($urandom % 100) < 4;
      svc  = ($urandom % 100) < 4;
      ret  = ($urandom % 100) < 8;
      wen  = ($urandom % 100) < 40;
      wsav = $urandom % 2;
      aen  = ($urandom % 100) < 40;
      wmask = 4'($urandom);
      aflags = 4'($urandom);
      wdata = $urandom;
      r = $urandom % 8;
      if (r < 5) wdata[4:0] = (r == 0) ? 5'h10 : (r == 1) ? 5'h11 :
                              (r == 2) ? 5'h12 : (r == 3) ? 5'h13 : 5'h1F;
      tick();
      check("R12 random live", status, m_live);
      check("R6 random saved", saved, m_saved_view());
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule